// File: doc/BRIEF.md
# Page Request Queue Writer

This block takes page requests from devices, one at a time, and appends each accepted request as a 128-bit descriptor to a circular queue held in system memory. Software describes the queue with a queue-address register (base address and a size code) and owns the head offset. The block reads the tail offset, writes the descriptor at base plus tail, and then hands back a new tail value for the register file to store.

Before any memory traffic the block screens each request. The checks are: whether the page-request capability is on, whether a PASID is present, whether an execute request also asks for read, and whether the device's context entry allows page requests. It then checks the queue state: a queue already marked as overflowed, or a queue that would become full. The result of every request comes back as a one-cycle response code. One-cycle strobes tell the status register to set its pending or overflow bit, tell the fault logic about a disallowed device, and tell the event controller to raise a page-request event. The event fires only when the status had neither bit set beforehand.

Top module: `prq_writer`

## Requirements
- R1: While and after synchronous reset, with no request applied, `req_ready` is 1. In the same state `mw_valid`, `rsp_valid`, `tail_we`, `pend_set`, `ovf_set`, `evt_trig` and `fault_pre` are all 0.
- R2: A request taken while `cap_en` is 0 completes with code PERM (3'd1). It makes no memory write, sends no fault and sets no status bit. This check has the highest priority.
- R3: A request with `req_pp`=0 completes with code PERM and no fault. A request with `req_exec`=1 and `req_rd`=0 completes with code INVAL (3'd2). Both are checked after R2 and before R4, with the PASID check first, and neither makes a memory write.
- R4: When the earlier checks pass and `ctx_pre` is 0, the block pulses `fault_pre` together with the response and completes with code PERM. It writes nothing to memory.
- R5: When `stat_ovf` is 1 and R2 to R4 pass, the request completes with code FULL (3'd3). No fault, no `ovf_set`, no `evt_trig` and no memory write accompany it.
- R6: When the next tail index equals the head index, the request completes with code FULL and pulses `ovf_set`. It pulses `evt_trig` only if `stat_pend` and `stat_ovf` were both 0, and it makes no memory write.
- R7: The descriptor sits in `mw_data[63:0]` (lower half) and `mw_data[127:64]` (upper half). The lower half holds type 2'b01 in [1:0], PASID-present = 1 in [2], privilege in [3], requester ID in [31:16] and PASID in [51:32]. The upper half holds read in [0], write in [1], last-in-group in [2], group index in [11:3] and page address bits 63:12 in [63:12]. Every other bit is 0.
- R8: `mw_addr` equals `qa_reg[63:12]`·4096 plus the tail offset `tail_off[18:5]`·32.
- R9: The queue has 2^(`qa_reg[2:0]`+7) entries. After a good write, `tail_we` pulses with `tail_wdata` = ((tail index + 1) mod entries)·32, which wraps to 0 at the last entry.
- R10: When a write completes with no error, the code is OK (3'd0). `pend_set` and `evt_trig` pulse only if `stat_pend` is 0 at completion, and `evt_trig` also needs `stat_ovf` to be 0.
- R11: When a write completes with `mw_err`=1, the code is BUSERR (3'd4). No `tail_we` and no `pend_set` follow.
- R12: Requests are handled one at a time. `req_ready` is 0 while `mw_valid` is 1, and `mw_valid` stays high with stable address and data until `mw_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Page-request capability enabled |
| qa_reg | input | 64 | Queue base [63:12] and size code [2:0] |
| head_off | input | 19 | Head byte offset, entry index in [18:5] |
| tail_off | input | 19 | Tail byte offset, entry index in [18:5] |
| stat_pend | input | 1 | Pending bit of the status register |
| stat_ovf | input | 1 | Overflow bit of the status register |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and taking a request |
| req_rid | input | 16 | Requester ID |
| req_pasid | input | 20 | PASID |
| req_pp | input | 1 | PASID present |
| req_priv | input | 1 | Privileged-mode request |
| req_exec | input | 1 | Execute requested |
| req_rd | input | 1 | Read requested |
| req_wr | input | 1 | Write requested |
| req_lpig | input | 1 | Last request in group |
| req_prgi | input | 9 | Group index |
| req_page | input | 52 | Page address bits 63:12 |
| ctx_pre | input | 1 | Page-request-enable bit of the context entry |
| mw_valid | output | 1 | Memory write request |
| mw_addr | output | 64 | Memory write byte address |
| mw_data | output | 128 | Descriptor, lower half in [63:0] |
| mw_done | input | 1 | Memory write completed |
| mw_err | input | 1 | Completion carries an error |
| tail_we | output | 1 | Tail register write strobe |
| tail_wdata | output | 19 | New tail byte offset |
| pend_set | output | 1 | Set pending bit |
| ovf_set | output | 1 | Set overflow bit |
| evt_trig | output | 1 | Page-request event trigger |
| fault_pre | output | 1 | Fault: page requests disallowed for device |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | OK 0, PERM 1, INVAL 2, FULL 3, BUSERR 4 |

## Verification
The hardest situation to reach is the queue wrapping into a full state. The tail must sit on the last index of a given size code while the head sits on index 0, so the increment has to fold back through the size mask before the comparison. The stimulus sets up that state directly through the head, tail and size inputs. It then changes only the size code, so the same tail becomes an ordinary accepted write with no wrap. A second hard case is the overlap of checks: a device that is disallowed while the queue is already overflowed must still be faulted. Vector rows with several refusal causes active together cover that priority order.

// File: rtl/prq_pkg.sv
package prq_pkg;
    localparam int AW       = 64;
    localparam int RID_W    = 16;
    localparam int PASID_W  = 20;
    localparam int PRGI_W   = 9;
    localparam int PQS_W    = 3;
    localparam int LOG_MIN  = 7;
    localparam int OFF_LSB  = 5;
    localparam int IDX_W    = (1 << PQS_W) - 1 + LOG_MIN;
    localparam int OFF_W    = IDX_W + OFF_LSB;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = AW - PAGE_LSB;
    localparam int HALF_W   = 64;
    localparam int DESC_W   = 2 * HALF_W;

    localparam int LO_PRIV_BIT  = 3;
    localparam int LO_RID_LSB   = 16;
    localparam int LO_PASID_LSB = 32;
    localparam int HI_PRGI_LSB  = 3;
    localparam logic [1:0] DESC_TYPE = 2'b01;

    typedef enum logic [2:0] {
        RC_OK     = 3'd0,
        RC_PERM   = 3'd1,
        RC_INVAL  = 3'd2,
        RC_FULL   = 3'd3,
        RC_BUSERR = 3'd4
    } rc_e;

    typedef enum logic {ST_IDLE, ST_WRITE} st_e;

    typedef struct packed {
        logic [RID_W-1:0]   rid;
        logic [PASID_W-1:0] pasid;
        logic               pp;
        logic               priv;
        logic               exe;
        logic               rd;
        logic               wr;
        logic               lpig;
        logic [PRGI_W-1:0]  prgi;
        logic [PAGE_W-1:0]  page;
    } preq_t;

    function automatic logic [IDX_W-1:0] idx_mask(input logic [PQS_W-1:0] pqs);
        logic [31:0] full;
        full = (32'd1 << (32'(pqs) + LOG_MIN)) - 32'd1;
        return full[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/prq_ring.sv
module prq_ring
    import prq_pkg::*;
(
    input  logic [AW-1:0]    qa_reg,
    input  logic [OFF_W-1:0] head_off,
    input  logic [OFF_W-1:0] tail_off,
    output logic [OFF_W-1:0] next_off,
    output logic             full,
    output logic [AW-1:0]    wr_addr
);
    logic [IDX_W-1:0] tidx, hidx, nidx, mask;

    always_comb begin
        mask     = idx_mask(qa_reg[PQS_W-1:0]);
        tidx     = tail_off[OFF_W-1:OFF_LSB];
        hidx     = head_off[OFF_W-1:OFF_LSB];
        nidx     = (tidx + IDX_W'(1)) & mask;
        full     = (nidx == hidx);
        next_off = {nidx, {OFF_LSB{1'b0}}};
        wr_addr  = {qa_reg[AW-1:PAGE_LSB], {PAGE_LSB{1'b0}}}
                 + AW'({tidx, {OFF_LSB{1'b0}}});
    end
endmodule

// File: rtl/prq_pack.sv
module prq_pack
    import prq_pkg::*;
(
    input  preq_t             req,
    output logic [DESC_W-1:0] desc
);
    logic [HALF_W-1:0] lo, hi;

    always_comb begin
        lo = '0;
        lo[1:0]                            = DESC_TYPE;
        lo[2]                              = 1'b1;
        lo[LO_PRIV_BIT]                    = req.priv;
        lo[LO_RID_LSB +: RID_W]            = req.rid;
        lo[LO_PASID_LSB +: PASID_W]        = req.pasid;
        hi = '0;
        hi[0]                              = req.rd;
        hi[1]                              = req.wr;
        hi[2]                              = req.lpig;
        hi[HI_PRGI_LSB +: PRGI_W]          = req.prgi;
        hi[HALF_W-1:PAGE_LSB]              = req.page;
        desc = {hi, lo};
    end
endmodule

// File: rtl/prq_screen.sv
module prq_screen
    import prq_pkg::*;
(
    input  logic  cap_en,
    input  preq_t req,
    input  logic  ctx_pre,
    input  logic  stat_ovf,
    input  logic  full,
    output logic  go,
    output rc_e   code,
    output logic  fault,
    output logic  ovf_hit
);
    always_comb begin
        go      = 1'b0;
        code    = RC_OK;
        fault   = 1'b0;
        ovf_hit = 1'b0;
        if (!cap_en || !req.pp) begin
            code = RC_PERM;
        end else if (req.exe && !req.rd) begin
            code = RC_INVAL;
        end else if (!ctx_pre) begin
            code  = RC_PERM;
            fault = 1'b1;
        end else if (stat_ovf) begin
            code = RC_FULL;
        end else if (full) begin
            code    = RC_FULL;
            ovf_hit = 1'b1;
        end else begin
            go = 1'b1;
        end
    end
endmodule

// File: rtl/prq_writer.sv
module prq_writer
    import prq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [AW-1:0]     qa_reg,
    input  logic [OFF_W-1:0]  head_off,
    input  logic [OFF_W-1:0]  tail_off,
    input  logic              stat_pend,
    input  logic              stat_ovf,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [PASID_W-1:0] req_pasid,
    input  logic              req_pp,
    input  logic              req_priv,
    input  logic              req_exec,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              req_lpig,
    input  logic [PRGI_W-1:0] req_prgi,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              ctx_pre,
    output logic              mw_valid,
    output logic [AW-1:0]     mw_addr,
    output logic [DESC_W-1:0] mw_data,
    input  logic              mw_done,
    input  logic              mw_err,
    output logic              tail_we,
    output logic [OFF_W-1:0]  tail_wdata,
    output logic              pend_set,
    output logic              ovf_set,
    output logic              evt_trig,
    output logic              fault_pre,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code
);
    st_e               state;
    preq_t             req;
    logic [OFF_W-1:0]  next_off, next_q;
    logic              full, go, fault, ovf_hit;
    logic [AW-1:0]     wr_addr;
    logic [DESC_W-1:0] desc;
    rc_e               code;

    assign req = '{rid: req_rid, pasid: req_pasid, pp: req_pp, priv: req_priv,
                   exe: req_exec, rd: req_rd, wr: req_wr, lpig: req_lpig,
                   prgi: req_prgi, page: req_page};

    prq_ring u_ring (
        .qa_reg(qa_reg), .head_off(head_off), .tail_off(tail_off),
        .next_off(next_off), .full(full), .wr_addr(wr_addr)
    );

    prq_pack u_pack (.req(req), .desc(desc));

    prq_screen u_screen (
        .cap_en(cap_en), .req(req), .ctx_pre(ctx_pre), .stat_ovf(stat_ovf),
        .full(full), .go(go), .code(code), .fault(fault), .ovf_hit(ovf_hit)
    );

    assign req_ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            mw_valid   <= 1'b0;
            mw_addr    <= '0;
            mw_data    <= '0;
            next_q     <= '0;
            tail_we    <= 1'b0;
            tail_wdata <= '0;
            pend_set   <= 1'b0;
            ovf_set    <= 1'b0;
            evt_trig   <= 1'b0;
            fault_pre  <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_code   <= RC_OK;
        end else begin
            tail_we   <= 1'b0;
            pend_set  <= 1'b0;
            ovf_set   <= 1'b0;
            evt_trig  <= 1'b0;
            fault_pre <= 1'b0;
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    if (go) begin
                        state    <= ST_WRITE;
                        mw_valid <= 1'b1;
                        mw_addr  <= wr_addr;
                        mw_data  <= desc;
                        next_q   <= next_off;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_code  <= code;
                        fault_pre <= fault;
                        ovf_set   <= ovf_hit;
                        evt_trig  <= ovf_hit && !stat_pend && !stat_ovf;
                    end
                end
                ST_WRITE: if (mw_done) begin
                    state     <= ST_IDLE;
                    mw_valid  <= 1'b0;
                    rsp_valid <= 1'b1;
                    if (mw_err) begin
                        rsp_code <= RC_BUSERR;
                    end else begin
                        rsp_code   <= RC_OK;
                        tail_we    <= 1'b1;
                        tail_wdata <= next_q;
                        pend_set   <= !stat_pend;
                        evt_trig   <= !stat_pend && !stat_ovf;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mw_valid |-> !req_ready);

    // R12
    hold_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_done) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    // R11
    err_no_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && mw_done && mw_err) |=> (!tail_we && !pend_set && rsp_code == RC_BUSERR));

    // R10
    pend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && mw_done && !mw_err && stat_pend) |=> (!pend_set && !evt_trig));

    // R5
    ovf_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && cap_en && req_pp && !(req_exec && !req_rd)
         && ctx_pre && stat_ovf)
        |=> (rsp_code == RC_FULL && !evt_trig && !ovf_set && !fault_pre && !mw_valid));

    // R4
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        fault_pre |-> (rsp_valid && rsp_code == RC_PERM));
endmodule

// File: tb/test_prq_writer.sv
module test_prq_writer;
    import prq_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic cap, pp, exe, rd, pre, ovf, pend;
        logic [2:0] pqs;
        logic [13:0] tl, hd;
        logic [2:0] code;
        logic fault, ovs, pns, evt, twe;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,14'd5,14'd0,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,14'd5,14'd0,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 no PASID
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,3'd0,14'd5,14'd0,3'd2,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 exec w/o read
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd0,14'd5,14'd0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b1}, // R10 ok
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,14'd5,14'd0,3'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // R4
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,14'd5,14'd0,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 over R4
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,3'd0,14'd5,14'd0,3'd3,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,3'd0,14'd5,14'd0,3'd1,1'b1,1'b0,1'b0,1'b0,1'b0}, // R4 over R5
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,14'd5,14'd6,3'd3,1'b0,1'b1,1'b0,1'b1,1'b0}, // R6 evt
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,3'd0,14'd5,14'd6,3'd3,1'b0,1'b1,1'b0,1'b0,1'b0}, // R6 no evt
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,3'd0,14'd5,14'd0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R10 pend held
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,14'd127,14'd0,3'd3,1'b0,1'b1,1'b0,1'b1,1'b0}, // R9 wrap full
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd1,14'd127,14'd0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b1}  // R9 no wrap
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cap_en = 1'b0, stat_pend = 1'b0, stat_ovf = 1'b0;
    logic [AW-1:0] qa_reg = '0;
    logic [OFF_W-1:0] head_off = '0, tail_off = '0;
    logic req_valid = 1'b0, req_ready;
    logic [RID_W-1:0] req_rid = 16'h0102;
    logic [PASID_W-1:0] req_pasid = 20'h00033;
    logic req_pp = 1'b0, req_priv = 1'b0, req_exec = 1'b0, req_rd = 1'b0;
    logic req_wr = 1'b0, req_lpig = 1'b0, ctx_pre = 1'b0;
    logic [PRGI_W-1:0] req_prgi = '0;
    logic [PAGE_W-1:0] req_page = '0;
    logic mw_valid, mw_done = 1'b0, mw_err = 1'b0;
    logic [AW-1:0] mw_addr;
    logic [DESC_W-1:0] mw_data;
    logic tail_we, pend_set, ovf_set, evt_trig, fault_pre, rsp_valid;
    logic [OFF_W-1:0] tail_wdata;
    logic [2:0] rsp_code;

    int checks = 0, errors = 0;
    logic got;
    logic [2:0] c_code;
    logic c_fault, c_ovs, c_pns, c_evt, c_twe, seen_rdy, seen_mw;
    logic [OFF_W-1:0] c_tail;
    logic [AW-1:0] c_addr;
    logic [DESC_W-1:0] c_data;

    prq_writer i_prq_writer (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic err);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0; seen_mw = 1'b0; seen_rdy = 1'b1;
        for (int k = 0; k < 20 && !got; k++) begin
            mw_done = 1'b0; mw_err = 1'b0;
            if (rsp_valid) begin
                got = 1'b1;
                c_code = rsp_code; c_fault = fault_pre; c_ovs = ovf_set;
                c_pns = pend_set; c_evt = evt_trig; c_twe = tail_we; c_tail = tail_wdata;
            end else begin
                if (mw_valid) begin
                    seen_mw = 1'b1; seen_rdy = req_ready;
                    c_addr = mw_addr; c_data = mw_data;
                    mw_done = 1'b1; mw_err = err;
                end
                @(negedge clk);
            end
        end
        mw_done = 1'b0; mw_err = 1'b0;
        chk(got, "R12 response missing", 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !mw_valid && !rsp_valid && !tail_we && !evt_trig,
            "R1 reset outputs", {req_ready, mw_valid, rsp_valid}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !mw_valid && !rsp_valid && !pend_set && !ovf_set && !fault_pre,
            "R1 idle after reset", {req_ready, mw_valid, rsp_valid}, 3'b100);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [13:0] msk, nx;
            v = VECS[i];
            cap_en = v.cap; req_pp = v.pp; req_exec = v.exe; req_rd = v.rd;
            ctx_pre = v.pre; stat_ovf = v.ovf; stat_pend = v.pend;
            qa_reg = {52'h0000_0100_0000_0, 9'd0, v.pqs};
            tail_off = {v.tl, 5'd0}; head_off = {v.hd, 5'd0};
            run_req(1'b0);
            chk(c_code == v.code, $sformatf("R2-6/9/10 vec %0d code", i), c_code, v.code);
            chk({c_fault, c_ovs, c_pns, c_evt, c_twe} == {v.fault, v.ovs, v.pns, v.evt, v.twe},
                $sformatf("R4 R5 R6 R10 vec %0d strobes", i),
                {c_fault, c_ovs, c_pns, c_evt, c_twe}, {v.fault, v.ovs, v.pns, v.evt, v.twe});
            chk(seen_mw == v.twe, $sformatf("R2 R3 R5 R6 vec %0d mem write", i), seen_mw, v.twe);
            if (v.twe) begin
                msk = 14'((32'd1 << (32'(v.pqs) + 7)) - 1);
                nx  = (v.tl + 14'd1) & msk;
                chk(c_tail == {nx, 5'd0}, $sformatf("R9 vec %0d tail", i), c_tail, {nx, 5'd0});
            end
        end

        // R7 R8 descriptor and address
        begin
            logic [63:0] elo, ehi, eaddr;
            cap_en = 1; req_pp = 1; req_exec = 0; req_rd = 1; req_wr = 0; ctx_pre = 1;
            stat_ovf = 0; stat_pend = 0; req_priv = 1; req_lpig = 1;
            req_rid = 16'hBEEF; req_pasid = 20'h5A5A5; req_prgi = 9'h1A5;
            req_page = 52'h0007FFF12345;
            qa_reg = 64'hABCD_1234_5678_9002;
            tail_off = {14'd10, 5'd0}; head_off = '0;
            run_req(1'b0);
            elo = 64'h1 | (64'h1 << 2) | (64'h1 << 3) | (64'(16'hBEEF) << 16)
                | (64'(20'h5A5A5) << 32);
            ehi = 64'h1 | (64'h1 << 2) | (64'(9'h1A5) << 3) | (64'h0007FFF12345 << 12);
            eaddr = 64'hABCD_1234_5678_9000 + 64'd320;
            chk(c_data[63:0] == elo, "R7 lower half", c_data[63:0], elo);
            chk(c_data[127:64] == ehi, "R7 upper half", c_data[127:64], ehi);
            chk(c_addr == eaddr, "R8 write address", c_addr, eaddr);
            chk(!seen_rdy, "R12 ready low while writing", seen_rdy, 0);
            chk(c_code == 3'd0 && c_tail == {14'd11, 5'd0}, "R9 R10 ok tail",
                {c_code, c_tail}, {3'd0, 14'd11, 5'd0});
        end

        // R11 bus error
        run_req(1'b1);
        chk(c_code == 3'd4, "R11 code", c_code, 3'd4);
        chk(!c_twe && !c_pns, "R11 no tail/pending", {c_twe, c_pns}, 2'b00);

        // R12 request held during write is not taken twice
        @(negedge clk);
        chk(req_ready && !mw_valid, "R12 back to idle", {req_ready, mw_valid}, 2'b10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule